// File: doc/BRIEF.md
# Multiplexed BCD Time Display Scanner

This block turns three packed-BCD bytes (hours, minutes, seconds) into the drive for an eight-position multiplexed seven-segment display. Only one position is lit at any moment. The block visits the positions in a fixed order: two hour digits, a dash, two minute digits, a dash and two second digits. The segment bus is active low. The position select is one-hot and active high.

Each position stays lit for a dwell time. That time is computed from the system clock frequency and a dwell duration in microseconds, both given as parameters. The first cycle of every dwell slot is blank, which keeps the previous pattern from ghosting onto the next position. The time bytes are copied into a holding register once per frame, so one pass over the eight positions always shows a single consistent time.

Top module: `bcd_clock_scan`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, `seg_no` is 8'hFF and `dig_sel_o` is zero. Scanning then starts at position 0.
- R2: Positions 0 to 7 show, in this order: hours tens, hours units, dash, minutes tens, minutes units, dash, seconds tens, seconds units. Position k is selected by `dig_sel_o[k]`.
- R3: Each tens digit is taken from bits [7:4] of its BCD byte. Each units digit is taken from bits [3:0].
- R4: Positions 2 and 5 always drive the pattern 8'hBF, so only the middle segment is lit.
- R5: The segment bus uses bit 0 = a through bit 6 = g, and bit 7 = point, which is always 1. A bit at 0 lights its segment. The digit codes for 0 to 9 are C0, F9, A4, B0, 99, 92, 82, F8, 80, 90.
- R6: A nibble above 9 drives 8'hFF, while its position is still selected.
- R7: Each position occupies exactly DWELL = CLK_HZ/1_000_000*DWELL_US clock cycles before the scan moves to the next one. After position 7 the scan wraps to position 0.
- R8: The first cycle of every slot is blank: `seg_no` = 8'hFF and `dig_sel_o` = 0.
- R9: The time inputs are captured at the clock edge that ends the blank cycle of position 0. Input changes after that edge do not appear until the next frame.
- R10: `dig_sel_o` never has more than one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hours_i | input | 8 | Hours, packed BCD |
| minutes_i | input | 8 | Minutes, packed BCD |
| seconds_i | input | 8 | Seconds, packed BCD |
| seg_no | output | 8 | Active-low segments, bit 0 = a through bit 6 = g, bit 7 = point |
| dig_sel_o | output | 8 | One-hot position select, active high |

## Verification
Two functions meet in the blank cycle of position 0: blanking the display at a digit change and capturing a new time for the frame. Both act in that single cycle. The bench changes the time inputs exactly in that blank cycle, and checks that the whole following frame shows the new value while the outputs stay blank during the cycle itself. It then changes the inputs one cycle later, just after the capture edge. The bench checks that this change is absent for the entire frame and appears only in the frame after.

// File: rtl/bcd_scan_pkg.sv
package bcd_scan_pkg;

    localparam int NUM_POS   = 8;
    localparam int NUM_BYTES = 3;

    typedef logic [7:0] seg_t;

    localparam seg_t SEG_OFF  = 8'hFF;
    localparam seg_t SEG_DASH = 8'hBF;

    typedef logic [NUM_BYTES-1:0][7:0] time_bcd_t;

    // every third position is a separator (2 and 5)
    function automatic bit is_separator(input int pos);
        return (pos % 3) == 2;
    endfunction

    // source byte index for a digit position: 0 hours, 1 minutes, 2 seconds
    function automatic int byte_of(input int pos);
        return pos / 3;
    endfunction

    // tens digit sits at the first position of each group
    function automatic bit is_tens(input int pos);
        return (pos % 3) == 0;
    endfunction

endpackage

// File: rtl/scan_dwell_ctr.sv
module scan_dwell_ctr #(
    parameter int DWELL = 8
) (
    input  logic clk_i,
    input  logic rst_ni,
    output logic slot_first_o,
    output logic slot_last_o
);
    localparam int CW = (DWELL > 1) ? $clog2(DWELL) : 1;
    localparam logic [CW-1:0] LAST = CW'(DWELL - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == LAST) st_d.cnt = '0;
        else                  st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign slot_first_o = (st_q.cnt == '0);
    assign slot_last_o  = (st_q.cnt == LAST);
endmodule

// File: rtl/scan_pos_ctr.sv
module scan_pos_ctr #(
    parameter int NPOS = 8,
    localparam int PW  = (NPOS > 1) ? $clog2(NPOS) : 1
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          advance_i,
    output logic [PW-1:0] pos_o
);
    localparam logic [PW-1:0] LAST = PW'(NPOS - 1);

    typedef struct packed {
        logic [PW-1:0] pos;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (advance_i) begin
            if (st_q.pos == LAST) st_d.pos = '0;
            else                  st_d.pos = st_q.pos + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign pos_o = st_q.pos;
endmodule

// File: rtl/seg_encode.sv
module seg_encode (
    input  logic [3:0] nib_i,
    output logic [7:0] seg_o
);
    // active low, bit0 = a ... bit6 = g, bit7 = point (kept dark)
    always_comb begin
        unique case (nib_i)
            4'd0:    seg_o = 8'hC0;
            4'd1:    seg_o = 8'hF9;
            4'd2:    seg_o = 8'hA4;
            4'd3:    seg_o = 8'hB0;
            4'd4:    seg_o = 8'h99;
            4'd5:    seg_o = 8'h92;
            4'd6:    seg_o = 8'h82;
            4'd7:    seg_o = 8'hF8;
            4'd8:    seg_o = 8'h80;
            4'd9:    seg_o = 8'h90;
            default: seg_o = 8'hFF;
        endcase
    end
endmodule

// File: rtl/bcd_clock_scan.sv
module bcd_clock_scan #(
    parameter int CLK_HZ   = 100_000_000,
    parameter int DWELL_US = 2000
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic [7:0] hours_i,
    input  logic [7:0] minutes_i,
    input  logic [7:0] seconds_i,
    output logic [7:0] seg_no,
    output logic [7:0] dig_sel_o
);
    import bcd_scan_pkg::*;

    localparam int DWELL = (CLK_HZ / 1_000_000) * DWELL_US;
    localparam int PW    = $clog2(NUM_POS);

    typedef struct packed {
        time_bcd_t hold;
    } state_t;

    state_t st_d, st_q;

    logic          slot_first;
    logic          slot_last;
    logic [PW-1:0] pos;
    logic          frame_start;
    seg_t          pat [NUM_POS];

    scan_dwell_ctr #(.DWELL(DWELL)) i_dwell (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .slot_first_o (slot_first),
        .slot_last_o  (slot_last)
    );

    scan_pos_ctr #(.NPOS(NUM_POS)) i_pos (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .advance_i (slot_last),
        .pos_o     (pos)
    );

    assign frame_start = slot_first && (pos == '0);

    always_comb begin
        st_d = st_q;
        if (frame_start) begin
            st_d.hold[0] = hours_i;
            st_d.hold[1] = minutes_i;
            st_d.hold[2] = seconds_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    for (genvar g = 0; g < NUM_POS; g++) begin : g_pos
        if (is_separator(g)) begin : g_sep
            assign pat[g] = SEG_DASH;
        end else begin : g_num
            localparam int BI = byte_of(g);
            logic [3:0] nib;
            assign nib = is_tens(g) ? st_q.hold[BI][7:4] : st_q.hold[BI][3:0];
            seg_encode i_enc (
                .nib_i (nib),
                .seg_o (pat[g])
            );
        end
    end

    always_comb begin
        if (slot_first) begin
            seg_no    = SEG_OFF;
            dig_sel_o = '0;
        end else begin
            seg_no    = pat[pos];
            dig_sel_o = 8'(1) << pos;
        end
    end
endmodule

// File: rtl/bcd_clock_scan_chk.sv
module bcd_clock_scan_chk (
    input logic        clk_i,
    input logic        rst_ni,
    input logic [7:0]  seg_no,
    input logic [7:0]  dig_sel_o,
    input logic [23:0] hold_i,
    input logic        frame_start_i
);
    always @(posedge clk_i) begin
        if (!rst_ni) begin
            assert_reset_blank_R1: assert (seg_no == 8'hFF && dig_sel_o == 8'h00)
                else $error("reset not blank");
        end
    end

    assert_sel_onehot_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(dig_sel_o));

    assert_gap_dark_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dig_sel_o == 8'h00) |-> (seg_no == 8'hFF));

    assert_dash_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dig_sel_o[2] || dig_sel_o[5]) |-> (seg_no == 8'hBF));

    assert_bad_nibble_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dig_sel_o[0] && hold_i[7:4] > 4'd9) |-> (seg_no == 8'hFF));

    assert_slot_steady_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dig_sel_o != 8'h00 && $past(dig_sel_o) != 8'h00) |-> $stable(dig_sel_o));

    assert_hold_frame_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !frame_start_i |=> $stable(hold_i));
endmodule

bind bcd_clock_scan bcd_clock_scan_chk i_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .seg_no        (seg_no),
    .dig_sel_o     (dig_sel_o),
    .hold_i        (st_q.hold),
    .frame_start_i (frame_start)
);

// File: tb/test_bcd_clock_scan.sv
module test_bcd_clock_scan;
    localparam int D     = 8;           // 4 MHz * 2 us
    localparam int FRAME = 8 * D;

    typedef struct packed {
        logic [23:0] t;    // hours, minutes, seconds
        logic [63:0] exp;  // position 0 in the top byte
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{24'h235924, 64'hA4B0BF9290BFA499},
        '{24'h000000, 64'hC0C0BFC0C0BFC0C0},
        '{24'h123456, 64'hF9A4BFB099BF9282},
        '{24'h071809, 64'hC0F8BFF980BFC090},
        '{24'h3AF5B0, 64'hB0FFBFFF92BFFFC0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] hr = '0, mn = '0, sc = '0;
    logic [7:0] seg_n, sel;
    int checks = 0, errors = 0;

    always #5 clk = ~clk;

    bcd_clock_scan #(.CLK_HZ(4_000_000), .DWELL_US(2)) i_bcd_clock_scan (
        .clk_i (clk), .rst_ni (rst_n),
        .hours_i (hr), .minutes_i (mn), .seconds_i (sc),
        .seg_no (seg_n), .dig_sel_o (sel)
    );

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %02h expected %02h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic set_time(input logic [23:0] t);
        {hr, mn, sc} = t;
    endtask

    // one frame after the blank slot-0 cycle; optional input change at step chg_at
    task automatic run_frame(input logic [63:0] exp, input int chg_at, input logic [23:0] chg_val);
        for (int i = 1; i <= FRAME; i++) begin
            int p;
            logic [7:0] e;
            string tag;
            @(posedge clk);
            @(negedge clk);
            p = (i / D) % 8;
            if (i % D == 0) begin
                check8("R8 gap segments", seg_n, 8'hFF);
                check8("R8 gap select", sel, 8'h00);
            end else begin
                e = exp[8*(7-p) +: 8];
                if (p == 2 || p == 5) tag = "R4 dash";
                else if (e == 8'hFF)  tag = "R6 invalid nibble";
                else                  tag = "R2/R3/R5/R9 digit";
                check8(tag, seg_n, e);
                check8("R7/R10 select", sel, 8'(1) << p);
            end
            if (i == chg_at) set_time(chg_val);
        end
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check8("R1 reset segments", seg_n, 8'hFF);
        check8("R1 reset select", sel, 8'h00);

        foreach (VECS[v]) begin
            rst_n = 1'b0;
            set_time(VECS[v].t);
            @(negedge clk);
            check8("R1 reset segments", seg_n, 8'hFF);
            rst_n = 1'b1;
            check8("R1 first cycle blank", seg_n, 8'hFF);
            run_frame(VECS[v].exp, -1, '0);
            run_frame(VECS[v].exp, -1, '0);
        end

        // R9: capture cycle vs. one cycle later
        rst_n = 1'b0;
        set_time(VECS[2].t);
        @(negedge clk);
        rst_n = 1'b1;
        run_frame(VECS[2].exp, FRAME, VECS[3].t);   // change in blank slot-0 cycle
        run_frame(VECS[3].exp, 1, VECS[4].t);       // change just after capture
        run_frame(VECS[4].exp, -1, '0);

        // R1: reset mid-frame blanks at once and restarts at position 0
        repeat (19) @(negedge clk);
        rst_n = 1'b0;
        #1;
        check8("R1 async reset segments", seg_n, 8'hFF);
        check8("R1 async reset select", sel, 8'h00);
        set_time(VECS[0].t);
        @(negedge clk);
        rst_n = 1'b1;
        run_frame(VECS[0].exp, -1, '0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule